// File: doc/BRIEF.md
# Channelized Signaling Serial Output

This block produces a serial signaling stream that runs in step with a serial T1 receive data stream. A frame is 193 bit times long: one framing-bit position, then 24 channel slots of 8 bit times each. In every channel slot the block drives that channel's four-bit signaling code (A, B, C, D) on the last four bit times. The code therefore lines up with the low nibble of the data byte that another block serializes in the same slot. All other bit times carry 0.

The block is driven by a bit clock and a frame start pulse, and it reads a flat store that holds all 24 codes. It keeps its own slot position and reports that position on two outputs: the channel index and the bit index inside the slot. When the superframe mode input is set, only A and B are meaningful, so the C and D positions repeat A and B. A channel's code and the mode are captured once, on the edge that enters the channel's slot. A change to either later in the slot does not alter the nibble that is already being sent.

Top module: `sig_serial_out`

## Requirements
- R1: While reset is asserted, `chan_idx`, `bit_idx` and `sig_out` are all 0.
- R2: When `frame_start` is high at a rising edge, the position after that edge is the framing position: `chan_idx` = 0 and `bit_idx` = 0.
- R3: After the framing position, the block steps through channels 1 to 24 in order, one bit time per clock. Each channel holds for 8 clocks with `bit_idx` counting 0 to 7, and `bit_idx` 0 is the first bit of the slot.
- R4: If no `frame_start` arrives, the position after channel 24, `bit_idx` 7, is the framing position again, so the period is 193 clocks.
- R5: `sig_out` is 0 at the framing position and at `bit_idx` 0 to 3 of every channel.
- R6: With `sf_mode` = 0, `sig_out` at `bit_idx` 4, 5, 6 and 7 of channel c is A, B, C, D. These are bits 3, 2, 1 and 0 of `sig_codes[4*c-1 : 4*c-4]`, in that order.
- R7: With `sf_mode` = 1, `bit_idx` 4 and 5 carry A and B, and `bit_idx` 6 and 7 repeat A and B.
- R8: A channel's code and `sf_mode` are sampled on the rising edge that moves the position to `bit_idx` 0 of that channel. Changes after that edge have no effect until the channel's next slot.
- R9: A `frame_start` pulse in the middle of a frame abandons the current slot. The block goes to the framing position and then continues with channel 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bit time per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the framing position for the next bit time |
| sf_mode | input | 1 | 1: superframe mode, C/D repeat A/B; 0: four independent bits |
| sig_codes | input | 96 | Code store; channel c in bits [4c-1:4c-4], A in the top bit |
| sig_out | output | 1 | Serial signaling bit |
| chan_idx | output | 5 | Current slot: 0 framing, 1..24 channel |
| bit_idx | output | 3 | Bit time inside the channel slot, 0..7 |

## Verification
The hardest case to create from the ports is a code or mode change that lands strictly inside a slot. The bench counts bit times from a frame start to a known position. It then changes channel 3's code and `sf_mode` on the falling edge after channel 3's slot has begun. It checks that channel 3 still carries the old nibble and that channel 4 picks up the new mode. A mid-frame restart pulse and a run with no pulse at all cover the two ways a frame can end.

// File: rtl/sig_pkg.sv
package sig_pkg;

    localparam int NIB_W = 4;

    // Superframe folding: positions C and D repeat A and B.
    function automatic logic [NIB_W-1:0] sf_fold(input logic [NIB_W-1:0] code,
                                                 input logic sf);
        logic [NIB_W-1:0] r;
        r = sf ? {code[3], code[2], code[3], code[2]} : code;
        return r;
    endfunction

endpackage

// File: rtl/sig_slot_timer.sv
module sig_slot_timer #(
    parameter int NUM_CHAN      = 24,
    parameter int BITS_PER_CHAN = 8,
    localparam int CW = $clog2(NUM_CHAN + 1),
    localparam int BW = $clog2(BITS_PER_CHAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic [CW-1:0] chan_q_o,
    output logic [BW-1:0] bit_q_o,
    output logic          load_en_o,
    output logic [CW-1:0] load_chan_o
);

    typedef struct packed {
        logic [CW-1:0] chan;
        logic [BW-1:0] bitn;
    } pos_t;

    localparam logic [CW-1:0] LAST_CHAN = CW'(NUM_CHAN);
    localparam logic [BW-1:0] LAST_BIT  = BW'(BITS_PER_CHAN - 1);

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (frame_start) begin
            pos_d.chan = '0;
            pos_d.bitn = '0;
        end else if (pos_q.chan == '0) begin
            pos_d.chan = CW'(1);
            pos_d.bitn = '0;
        end else if (pos_q.bitn == LAST_BIT) begin
            pos_d.chan = (pos_q.chan == LAST_CHAN) ? '0 : pos_q.chan + CW'(1);
            pos_d.bitn = '0;
        end else begin
            pos_d.bitn = pos_q.bitn + BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign chan_q_o    = pos_q.chan;
    assign bit_q_o     = pos_q.bitn;
    assign load_en_o   = (pos_d.chan != '0) && (pos_d.bitn == '0);
    assign load_chan_o = pos_d.chan;

endmodule

// File: rtl/sig_code_latch.sv
module sig_code_latch
    import sig_pkg::*;
#(
    parameter int NUM_CHAN = 24,
    localparam int CW = $clog2(NUM_CHAN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sf_mode,
    input  logic [NUM_CHAN*NIB_W-1:0] sig_codes,
    input  logic                      load_en,
    input  logic [CW-1:0]             load_chan,
    output logic [NIB_W-1:0]          nib_q_o
);

    logic [NIB_W-1:0] folded [NUM_CHAN];

    genvar g;
    generate
        for (g = 0; g < NUM_CHAN; g++) begin : g_fold
            assign folded[g] = sf_fold(sig_codes[g*NIB_W +: NIB_W], sf_mode);
        end
    endgenerate

    typedef struct packed {
        logic [NIB_W-1:0] nib;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (load_en) begin
            lat_d.nib = '0;
            for (int c = 0; c < NUM_CHAN; c++) begin
                if (load_chan == CW'(c + 1)) lat_d.nib = folded[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign nib_q_o = lat_q.nib;

endmodule

// File: rtl/sig_bit_mux.sv
module sig_bit_mux
    import sig_pkg::*;
#(
    parameter int NUM_CHAN      = 24,
    parameter int BITS_PER_CHAN = 8,
    localparam int CW = $clog2(NUM_CHAN + 1),
    localparam int BW = $clog2(BITS_PER_CHAN)
) (
    input  logic [CW-1:0]    chan,
    input  logic [BW-1:0]    bitn,
    input  logic [NIB_W-1:0] nib,
    output logic             sig_o
);

    localparam logic [BW-1:0] FIELD_START = BW'(BITS_PER_CHAN - NIB_W);

    logic [BW-1:0]    off;
    logic [NIB_W-1:0] shifted;

    always_comb begin
        off     = bitn - FIELD_START;
        shifted = nib << off;
        sig_o   = 1'b0;
        if ((chan != '0) && (bitn >= FIELD_START)) sig_o = shifted[NIB_W-1];
    end

endmodule

// File: rtl/sig_serial_out.sv
module sig_serial_out
    import sig_pkg::*;
#(
    parameter int NUM_CHAN      = 24,
    parameter int BITS_PER_CHAN = 8,
    localparam int CW = $clog2(NUM_CHAN + 1),
    localparam int BW = $clog2(BITS_PER_CHAN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      sf_mode,
    input  logic [NUM_CHAN*NIB_W-1:0] sig_codes,
    output logic                      sig_out,
    output logic [CW-1:0]             chan_idx,
    output logic [BW-1:0]             bit_idx
);

    logic             load_en;
    logic [CW-1:0]    load_chan;
    logic [NIB_W-1:0] nib;

    sig_slot_timer #(.NUM_CHAN(NUM_CHAN), .BITS_PER_CHAN(BITS_PER_CHAN)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .chan_q_o    (chan_idx),
        .bit_q_o     (bit_idx),
        .load_en_o   (load_en),
        .load_chan_o (load_chan)
    );

    sig_code_latch #(.NUM_CHAN(NUM_CHAN)) latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sf_mode   (sf_mode),
        .sig_codes (sig_codes),
        .load_en   (load_en),
        .load_chan (load_chan),
        .nib_q_o   (nib)
    );

    sig_bit_mux #(.NUM_CHAN(NUM_CHAN), .BITS_PER_CHAN(BITS_PER_CHAN)) mux_i (
        .chan  (chan_idx),
        .bitn  (bit_idx),
        .nib   (nib),
        .sig_o (sig_out)
    );

endmodule

// File: rtl/sig_serial_out_chk.sv
module sig_serial_out_chk #(
    parameter int NUM_CHAN      = 24,
    parameter int BITS_PER_CHAN = 8,
    localparam int CW = $clog2(NUM_CHAN + 1),
    localparam int BW = $clog2(BITS_PER_CHAN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          sig_out,
    input logic [CW-1:0] chan_idx,
    input logic [BW-1:0] bit_idx
);

    localparam logic [CW-1:0] LAST_CHAN = CW'(NUM_CHAN);
    localparam logic [BW-1:0] LAST_BIT  = BW'(BITS_PER_CHAN - 1);
    localparam logic [BW-1:0] FIELD_ST  = BW'(BITS_PER_CHAN - 4);

    a_r2_start_to_framing: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (chan_idx == '0) && (bit_idx == '0));

    a_r3_bit_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && chan_idx != '0 && bit_idx != LAST_BIT)
        |=> (bit_idx == $past(bit_idx) + BW'(1)) && $stable(chan_idx));

    a_r3_framing_to_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && chan_idx == '0) |=> (chan_idx == CW'(1)) && (bit_idx == '0));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && chan_idx == LAST_CHAN && bit_idx == LAST_BIT) |=> (chan_idx == '0));

    a_r5_quiet_positions: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_idx == '0 || bit_idx < FIELD_ST) |-> !sig_out);

endmodule

bind sig_serial_out sig_serial_out_chk #(
    .NUM_CHAN(NUM_CHAN), .BITS_PER_CHAN(BITS_PER_CHAN)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .sig_out     (sig_out),
    .chan_idx    (chan_idx),
    .bit_idx     (bit_idx)
);

// File: tb/sig_serial_out_tb_top.sv
module sig_serial_out_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        sf_mode = 1'b0;
    logic [95:0] sig_codes = '0;
    logic        sig_out;
    logic [4:0]  chan_idx;
    logic [2:0]  bit_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sig_serial_out dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sf_mode(sf_mode),
        .sig_codes(sig_codes), .sig_out(sig_out), .chan_idx(chan_idx), .bit_idx(bit_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] fold(input logic [3:0] c, input logic sf);
        return sf ? {c[3], c[2], c[3], c[2]} : c;
    endfunction

    function automatic logic [3:0] code_of(input int c);
        return sig_codes[4*(c-1) +: 4];
    endfunction

    // Check position p (0..192) against expected channel, bit and signal.
    task automatic chk_pos(input int p, input logic [3:0] nib, input string req);
        int c, b;
        logic e;
        c = (p == 0) ? 0 : (p - 1) / 8 + 1;
        b = (p == 0) ? 0 : (p - 1) % 8;
        e = (c != 0 && b >= 4) ? nib[3 - (b - 4)] : 1'b0;
        chk(chan_idx == 5'(c), {req, " chan (R3)"}, int'(chan_idx), c);
        chk(bit_idx == 3'(b), {req, " bit (R3)"}, int'(bit_idx), b);
        chk(sig_out == e, {req, " sig"}, int'(sig_out), int'(e));
    endtask

    task automatic pulse_start();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(chan_idx == 0, "R1 chan", int'(chan_idx), 0);
        chk(bit_idx == 0, "R1 bit", int'(bit_idx), 0);
        chk(sig_out == 0, "R1 sig", int'(sig_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_full_frame(input logic sf, input string req);
        sf_mode = sf;
        pulse_start();
        chk(chan_idx == 0 && bit_idx == 0, "R2 framing", int'(chan_idx), 0);
        for (int p = 0; p < 193; p++) begin
            int c;
            c = (p == 0) ? 1 : (p - 1) / 8 + 1;
            chk_pos(p, fold(code_of(c), sf), req);
            @(negedge clk);
        end
        // R4: no pulse, wraps back to framing
        chk(chan_idx == 0 && bit_idx == 0, "R4 wrap framing", int'(chan_idx), 0);
        @(negedge clk);
        chk(chan_idx == 1 && bit_idx == 0, "R4 wrap to ch1", int'(chan_idx), 1);
    endtask

    task automatic t_midslot();
        logic [3:0] old3;
        sig_codes[4*2 +: 4] = 4'b0110;
        sig_codes[4*3 +: 4] = 4'b1001;
        sf_mode = 1'b0;
        pulse_start();
        for (int p = 0; p < 17; p++) @(negedge clk);
        old3 = 4'b0110;
        chk(chan_idx == 3 && bit_idx == 0, "R8 at ch3 start", int'(chan_idx), 3);
        sig_codes[4*2 +: 4] = 4'b1011;
        sf_mode = 1'b1;
        for (int p = 17; p < 25; p++) begin
            chk_pos(p, old3, "R8 held nibble");
            @(negedge clk);
        end
        for (int p = 25; p < 33; p++) begin
            chk_pos(p, fold(4'b1001, 1'b1), "R8 R7 next slot");
            @(negedge clk);
        end
        sf_mode = 1'b0;
    endtask

    task automatic t_restart();
        pulse_start();
        for (int p = 0; p < 78; p++) @(negedge clk);
        chk(chan_idx == 10 && bit_idx == 5, "R9 pre", int'(chan_idx), 10);
        pulse_start();
        chk(chan_idx == 0 && bit_idx == 0, "R9 restart framing", int'(chan_idx), 0);
        chk(sig_out == 0, "R9 R5 framing sig", int'(sig_out), 0);
        @(negedge clk);
        chk(chan_idx == 1 && bit_idx == 0, "R9 restart ch1", int'(chan_idx), 1);
    endtask

    initial begin
        t_reset();
        for (int c = 1; c <= 24; c++) sig_codes[4*(c-1) +: 4] = 4'((c * 7 + 3) % 16);
        t_full_frame(1'b0, "R6 R5 esf");
        for (int c = 1; c <= 24; c++) sig_codes[4*(c-1) +: 4] = 4'((c * 5 + 9) % 16);
        t_full_frame(1'b1, "R7 R5 sf");
        t_midslot();
        t_restart();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule